// File: doc/BRIEF.md
# Flash Command Sequencer with Block Protection

This block turns a stream of byte-wide bus writes into commands for a small on-chip flash model. A command starts with two unlock writes, byte 0xAA at address 0x0555 and then byte 0x55 at address 0x0AAA. A third write to 0x0555 carries the command byte. Four command families are understood: identification read, return to read mode, setting the protection bit of a single block, and clearing protection bits one group of four at a time. Reads are combinational. In read mode they return array contents. In identification mode they return an identification field, whatever flash address is read.

Setting and clearing protection run as timed automatic operations. A fixed internal count sets their length, and the ready flag is low while one runs. No bus write is accepted during that window. Only the synchronous hardware reset can cut an operation short. The protection field has one bit per block. It is always visible on its own output port and can also be read as identification fields.

Top module: `fcs_sequencer`

## Requirements
- R1: A write that departs from the expected next step of any sequence (wrong address or wrong byte) sends the decoder back to read mode. A write of 0xF0 during the unlock steps also returns it to read mode.
- R2: The sequence AA@0x0555, 55@0x0AAA, 0x90@0x0555, followed by a fourth write of any byte other than 0xF0, enters identification mode. Address bits [15:14] of that fourth write select the field: 0 gives 0x5A, 1 gives 0xC3, 2 gives protection bits [7:0], 3 gives protection bits [15:8]. Every read at any address then returns that field.
- R3: Identification mode persists. Each further write of a byte other than 0xF0 re-selects the field from its address bits [15:14].
- R4: A write of byte 0xF0 at any address leaves identification mode and restores array reads.
- R5: In read mode, a read at address A returns A[7:0] XOR A[15:8] XOR 0x3C.
- R6: `ready_o` falls in the cycle after the write that launches an automatic operation. It stays low for exactly 64 cycles, and the operation's effect on the protection field appears in the same cycle that `ready_o` returns high.
- R7: All bus writes are ignored while `ready_o` is low. Decoder state, protection bits and the identification selection are left unchanged.
- R8: The sequence AA@0x0555, 55@0x0AAA, 0x9A@0x0555, then a write whose byte bits [3:0] hold block b, sets protection bit b when the operation ends.
- R9: The seven-write sequence AA@0x0555, 55@0x0AAA, 0x60@0x0555, AA@0x0555, 55@0x0AAA, 0x40@0x0555, then any write whose byte bits [1:0] hold group g, clears protection bits 4g to 4g+3 when the operation ends. The decoder is then in read mode.
- R10: A synchronous reset aborts any automatic operation and puts the decoder in read mode. `ready_o` reads 1 in the next cycle, and the protection field takes its initial value (all ones).
- R11: While `bus_rd_i` is low, `bus_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_rd_i | input | 1 | Read enable |
| bus_addr_i | input | 16 | Bus address for reads and writes |
| bus_wdata_i | input | 8 | Write byte |
| bus_rdata_o | output | 8 | Read byte (combinational) |
| ready_o | output | 1 | 1 when idle, 0 during an automatic operation |
| prot_o | output | 16 | Protection bit per block |

## Verification
The command decoder is driven with complete sequences of every kind and with sequences broken at each step: wrong address, wrong byte, and an early 0xF0. This separates a decoder that falls back to read mode from one that holds partial progress. Identification mode is tried with repeated fourth writes covering all four address codes, so a field mux stuck on one code shows up. Reads at several addresses show that the mode, and not the address, picks the data. Automatic operations are run with writes landing inside the busy window, with operations placed back to back, and with a reset in mid-operation. Comparing every cycle against a behavioural model pins down the exact busy length and the cycle in which the protection field changes.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] UNL_ADDR_A = 16'h0555;
    localparam logic [ADDR_W-1:0] UNL_ADDR_B = 16'h0AAA;
    localparam logic [DATA_W-1:0] UNL_BYTE_A = 8'hAA;
    localparam logic [DATA_W-1:0] UNL_BYTE_B = 8'h55;
    localparam logic [DATA_W-1:0] CMD_IDENT  = 8'h90;
    localparam logic [DATA_W-1:0] CMD_RESET  = 8'hF0;
    localparam logic [DATA_W-1:0] CMD_PSET   = 8'h9A;
    localparam logic [DATA_W-1:0] CMD_PCLR   = 8'h60;
    localparam logic [DATA_W-1:0] CMD_PCONF  = 8'h40;
    localparam logic [DATA_W-1:0] ARRAY_SALT = 8'h3C;

    typedef enum logic [3:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_ID_ARM, ST_ID,
        ST_PSET_BLK, ST_PCLR_A, ST_PCLR_B, ST_PCLR_C, ST_PCLR_GRP
    } seq_st_t;

    typedef enum logic {
        OP_PSET = 1'b0,
        OP_PCLR = 1'b1
    } auto_op_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    function automatic logic wr_hit(input bus_wr_t w, input logic [ADDR_W-1:0] a,
                                    input logic [DATA_W-1:0] d);
        return (w.addr == a) && (w.data == d);
    endfunction

    function automatic logic [DATA_W-1:0] array_byte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ ARRAY_SALT;
    endfunction

    function automatic logic [DATA_W-1:0] id_field(input logic [1:0] sel,
                                                   input logic [DATA_W-1:0] maker,
                                                   input logic [DATA_W-1:0] dev,
                                                   input logic [15:0] prot16);
        logic [DATA_W-1:0] r;
        unique case (sel)
            2'd0:    r = maker;
            2'd1:    r = dev;
            2'd2:    r = prot16[7:0];
            default: r = prot16[15:8];
        endcase
        return r;
    endfunction
endpackage

// File: rtl/fcs_cmd_decoder.sv
`timescale 1ns/1ps
module fcs_cmd_decoder import fcs_pkg::*; #(
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy_i,
    input  bus_wr_t          wr_i,
    output logic             id_mode_o,
    output logic [1:0]       id_sel_o,
    output logic             start_o,
    output auto_op_t         op_o,
    output logic [BLK_W-1:0] arg_o
);
    seq_st_t    st_q, st_d;
    logic [1:0] sel_q, sel_d;

    always_comb begin
        st_d    = st_q;
        sel_d   = sel_q;
        start_o = 1'b0;
        op_o    = OP_PSET;
        arg_o   = wr_i.data[BLK_W-1:0];
        if (wr_i.vld && !busy_i) begin
            unique case (st_q)
                ST_READ: begin
                    if (wr_hit(wr_i, UNL_ADDR_A, UNL_BYTE_A)) st_d = ST_UNL1;
                end
                ST_UNL1: st_d = wr_hit(wr_i, UNL_ADDR_B, UNL_BYTE_B) ? ST_UNL2 : ST_READ;
                ST_UNL2: begin
                    st_d = ST_READ;
                    if (wr_i.addr == UNL_ADDR_A) begin
                        if (wr_i.data == CMD_IDENT)      st_d = ST_ID_ARM;
                        else if (wr_i.data == CMD_PSET)  st_d = ST_PSET_BLK;
                        else if (wr_i.data == CMD_PCLR)  st_d = ST_PCLR_A;
                    end
                end
                ST_ID_ARM, ST_ID: begin
                    if (wr_i.data == CMD_RESET) begin
                        st_d = ST_READ;
                    end else begin
                        sel_d = wr_i.addr[15:14];
                        st_d  = ST_ID;
                    end
                end
                ST_PSET_BLK: begin
                    start_o = 1'b1;
                    op_o    = OP_PSET;
                    st_d    = ST_READ;
                end
                ST_PCLR_A: st_d = wr_hit(wr_i, UNL_ADDR_A, UNL_BYTE_A) ? ST_PCLR_B : ST_READ;
                ST_PCLR_B: st_d = wr_hit(wr_i, UNL_ADDR_B, UNL_BYTE_B) ? ST_PCLR_C : ST_READ;
                ST_PCLR_C: st_d = wr_hit(wr_i, UNL_ADDR_A, CMD_PCONF) ? ST_PCLR_GRP : ST_READ;
                ST_PCLR_GRP: begin
                    start_o = 1'b1;
                    op_o    = OP_PCLR;
                    st_d    = ST_READ;
                end
                default: st_d = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_READ;
            sel_q <= 2'd0;
        end else begin
            st_q  <= st_d;
            sel_q <= sel_d;
        end
    end

    assign id_mode_o = (st_q == ST_ID);
    assign id_sel_o  = sel_q;

    // R7
    busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && wr_i.vld) |=> ($stable(st_q) && $stable(sel_q)));

    // R4
    id_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (id_mode_o && !busy_i && wr_i.vld && wr_i.data == CMD_RESET) |=> !id_mode_o);

    // R1
    unl_break_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_UNL1 && !busy_i && wr_i.vld && wr_i.addr != UNL_ADDR_B) |=> (st_q == ST_READ));
endmodule

// File: rtl/fcs_auto_timer.sv
`timescale 1ns/1ps
module fcs_auto_timer import fcs_pkg::*; #(
    parameter int CYCLES = 64,
    parameter int ARG_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  auto_op_t         op_i,
    input  logic [ARG_W-1:0] arg_i,
    output logic             busy_o,
    output logic             done_o,
    output auto_op_t         op_o,
    output logic [ARG_W-1:0] arg_o
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    auto_op_t         op_q;
    logic [ARG_W-1:0] arg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_PSET;
            arg_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            op_q   <= op_i;
            arg_q  <= arg_i;
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == LAST);
    assign op_o   = op_q;
    assign arg_o  = arg_q;

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> busy_o);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    // R7
    no_start_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !start_i);
endmodule

// File: rtl/fcs_prot_bank.sv
`timescale 1ns/1ps
module fcs_prot_bank import fcs_pkg::*; #(
    parameter int NUM_BLK  = 16,
    parameter int GRP_SIZE = 4,
    parameter int ARG_W    = 4,
    parameter logic [NUM_BLK-1:0] INIT = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               done_i,
    input  auto_op_t           op_i,
    input  logic [ARG_W-1:0]   arg_i,
    output logic [NUM_BLK-1:0] prot_o
);
    localparam int NUM_GRP = NUM_BLK / GRP_SIZE;
    localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

    logic [NUM_BLK-1:0] prot_q;
    logic [NUM_BLK-1:0] set_v;
    logic [NUM_BLK-1:0] clr_v;

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        localparam int GRP = b / GRP_SIZE;
        assign set_v[b] = (op_i == OP_PSET) && (arg_i == ARG_W'(b));
        assign clr_v[b] = (op_i == OP_PCLR) && (arg_i[GRP_W-1:0] == GRP_W'(GRP));
    end

    always_ff @(posedge clk) begin
        if (rst)         prot_q <= INIT;
        else if (done_i) prot_q <= (prot_q | set_v) & ~clr_v;
    end

    assign prot_o = prot_q;

    // R8
    pset_applied_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && op_i == OP_PSET) |=> ((prot_o & $past(set_v)) == $past(set_v)));

    // R9
    pclr_applied_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && op_i == OP_PCLR) |=> ((prot_o & $past(clr_v)) == '0));

    // R7
    prot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_i |=> $stable(prot_o));
endmodule

// File: rtl/fcs_sequencer.sv
`timescale 1ns/1ps
module fcs_sequencer import fcs_pkg::*; #(
    parameter int NUM_BLK     = 16,
    parameter int GRP_SIZE    = 4,
    parameter int AUTO_CYCLES = 64,
    parameter logic [7:0] MAKER_CODE  = 8'h5A,
    parameter logic [7:0] DEVICE_CODE = 8'hC3,
    parameter logic [NUM_BLK-1:0] PROT_INIT = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [15:0]        bus_addr_i,
    input  logic [7:0]         bus_wdata_i,
    output logic [7:0]         bus_rdata_o,
    output logic               ready_o,
    output logic [NUM_BLK-1:0] prot_o
);
    localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;

    bus_wr_t    wr_s;
    logic       id_mode;
    logic [1:0] id_sel;
    logic       start;
    auto_op_t   dec_op, run_op;
    logic [BLK_W-1:0] dec_arg, run_arg;
    logic       busy, done;
    logic [15:0] prot16;

    assign wr_s.vld  = bus_wr_i;
    assign wr_s.addr = bus_addr_i;
    assign wr_s.data = bus_wdata_i;

    fcs_cmd_decoder #(.BLK_W(BLK_W)) u_dec (
        .clk(clk), .rst(rst), .busy_i(busy), .wr_i(wr_s),
        .id_mode_o(id_mode), .id_sel_o(id_sel),
        .start_o(start), .op_o(dec_op), .arg_o(dec_arg)
    );

    fcs_auto_timer #(.CYCLES(AUTO_CYCLES), .ARG_W(BLK_W)) u_tmr (
        .clk(clk), .rst(rst), .start_i(start), .op_i(dec_op), .arg_i(dec_arg),
        .busy_o(busy), .done_o(done), .op_o(run_op), .arg_o(run_arg)
    );

    fcs_prot_bank #(.NUM_BLK(NUM_BLK), .GRP_SIZE(GRP_SIZE), .ARG_W(BLK_W),
                    .INIT(PROT_INIT)) u_prot (
        .clk(clk), .rst(rst), .done_i(done), .op_i(run_op), .arg_i(run_arg),
        .prot_o(prot_o)
    );

    if (NUM_BLK >= 16) begin : g_p16_trunc
        assign prot16 = prot_o[15:0];
    end else begin : g_p16_pad
        assign prot16 = {{(16-NUM_BLK){1'b0}}, prot_o};
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            if (id_mode) bus_rdata_o = id_field(id_sel, MAKER_CODE, DEVICE_CODE, prot16);
            else         bus_rdata_o = array_byte(bus_addr_i);
        end
    end

    assign ready_o = !busy;

    // R10
    rst_ready_chk: assert property (@(posedge clk) rst |=> (ready_o && !id_mode));

    // R6
    ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !ready_o);
endmodule

// File: tb/fcs_sequencer_tb_top.sv
`timescale 1ns/1ps
module fcs_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ready;
    logic [15:0] prot;

    always #4 clk = ~clk;

    fcs_sequencer dut_i (
        .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .ready_o(ready), .prot_o(prot)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R10";

    // behavioural reference state
    int          m_state = 0;   // 0 read,1 u1,2 u2,3 id arm,4 id,5 pset,6..8 pclr steps,9 pclr grp
    int          m_sel = 0;
    int          m_busy = 0;
    int          m_cnt = 0;
    int          m_op = 0;
    int          m_arg = 0;
    logic [15:0] m_prot = 16'hFFFF;
    bit          m_valid = 0;

    function automatic logic [7:0] exp_rdata(input logic rd, input logic [15:0] a);
        if (!rd) return 8'h00;
        if (m_state == 4) begin
            case (m_sel)
                0: return 8'h5A;
                1: return 8'hC3;
                2: return m_prot[7:0];
                default: return m_prot[15:8];
            endcase
        end
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic model_step(input logic r, input logic w, input logic [15:0] a,
                              input logic [7:0] d);
        if (r) begin
            m_state = 0; m_sel = 0; m_busy = 0; m_cnt = 0; m_prot = 16'hFFFF; m_valid = 1;
        end else if (m_busy != 0) begin
            m_cnt++;
            if (m_cnt == 64) begin
                m_busy = 0;
                if (m_op == 0) m_prot[m_arg] = 1'b1;
                else for (int k = 0; k < 4; k++) m_prot[m_arg*4 + k] = 1'b0;
            end
        end else if (w) begin
            case (m_state)
                0: if (a == 16'h0555 && d == 8'hAA) m_state = 1;
                1: m_state = (a == 16'h0AAA && d == 8'h55) ? 2 : 0;
                2: begin
                    if (a != 16'h0555) m_state = 0;
                    else if (d == 8'h90) m_state = 3;
                    else if (d == 8'h9A) m_state = 5;
                    else if (d == 8'h60) m_state = 6;
                    else m_state = 0;
                end
                3, 4: begin
                    if (d == 8'hF0) m_state = 0;
                    else begin m_sel = int'(a[15:14]); m_state = 4; end
                end
                5: begin m_busy = 1; m_cnt = 0; m_op = 0; m_arg = int'(d[3:0]); m_state = 0; end
                6: m_state = (a == 16'h0555 && d == 8'hAA) ? 7 : 0;
                7: m_state = (a == 16'h0AAA && d == 8'h55) ? 8 : 0;
                8: m_state = (a == 16'h0555 && d == 8'h40) ? 9 : 0;
                9: begin m_busy = 1; m_cnt = 0; m_op = 1; m_arg = int'(d[1:0]); m_state = 0; end
                default: m_state = 0;
            endcase
        end
    endtask

    task automatic cyc(input logic r, input logic w, input logic rd,
                       input logic [15:0] a, input logic [7:0] d);
        logic [7:0] er;
        rst = r; bus_wr = w; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1;
        if (m_valid) begin
            er = exp_rdata(rd, a);
            checks++;
            if (bus_rdata !== er) begin
                errors++;
                $display("FAIL %s rdata @%h: actual %h expected %h", cur_req, a, bus_rdata, er);
            end
            checks++;
            if (ready !== (m_busy == 0)) begin
                errors++;
                $display("FAIL %s ready: actual %b expected %b", cur_req, ready, (m_busy == 0));
            end
            checks++;
            if (prot !== m_prot) begin
                errors++;
                $display("FAIL %s prot: actual %h expected %h", cur_req, prot, m_prot);
            end
        end
        @(posedge clk);
        model_step(r, w, a, d);
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b1, 1'b0, a, d);
    endtask
    task automatic rdx(input logic [15:0] a);
        cyc(1'b0, 1'b0, 1'b1, a, 8'h00);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, 16'(i * 16'h0123), 8'h00);
    endtask
    task automatic unlock();
        wr(16'h0555, 8'hAA);
        wr(16'h0AAA, 8'h55);
    endtask
    task automatic clr_group(input logic [7:0] g);
        unlock(); wr(16'h0555, 8'h60);
        unlock(); wr(16'h0555, 8'h40);
        wr(16'h1234, g);
    endtask

    initial begin
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        cur_req = "R10";
        cyc(1'b1, 1'b0, 1'b0, 16'h0, 8'h0);
        cyc(1'b1, 1'b0, 1'b0, 16'h0, 8'h0);
        idle(2);

        cur_req = "R5";
        rdx(16'h0000); rdx(16'h0555); rdx(16'hABCD); rdx(16'hFFFF);
        cur_req = "R11";
        cyc(1'b0, 1'b0, 1'b0, 16'hABCD, 8'h00);

        cur_req = "R2";
        unlock(); wr(16'h0555, 8'h90);
        rdx(16'h2222);
        wr(16'h4000, 8'h00);
        rdx(16'h0000); rdx(16'h7777); rdx(16'hFFFF);
        cur_req = "R3";
        wr(16'h0000, 8'h00); rdx(16'h1111);
        wr(16'h8000, 8'h00); rdx(16'h1111);
        wr(16'hC123, 8'h11); rdx(16'h5555);
        wr(16'h0555, 8'hAA); rdx(16'h5555);
        cur_req = "R4";
        wr(16'h3333, 8'hF0); rdx(16'h5555); rdx(16'h4000);

        cur_req = "R1";
        wr(16'h0555, 8'hAA); wr(16'h0AAB, 8'h55); wr(16'h0555, 8'h90); wr(16'h4000, 8'h00);
        rdx(16'h0101);
        unlock(); wr(16'h0556, 8'h90); wr(16'h4000, 8'h00); rdx(16'h0202);
        unlock(); wr(16'h0555, 8'hF0); rdx(16'h0303);
        unlock(); wr(16'h0555, 8'h60); wr(16'h0555, 8'hAB); wr(16'h0555, 8'h40);
        wr(16'h0000, 8'h01); idle(3);

        cur_req = "R9";
        clr_group(8'h01);
        cur_req = "R7";
        unlock(); wr(16'h0555, 8'h90); wr(16'h4000, 8'h00);
        unlock(); wr(16'h0555, 8'h9A); wr(16'h0000, 8'h03);
        cur_req = "R6";
        idle(60);
        rdx(16'h0F0F);
        cur_req = "R9";
        clr_group(8'h00); idle(66);
        clr_group(8'h02); idle(66);

        cur_req = "R8";
        unlock(); wr(16'h0555, 8'h9A); wr(16'h0000, 8'h05); idle(66);
        cur_req = "R2";
        unlock(); wr(16'h0555, 8'h90); wr(16'h8000, 8'h00); rdx(16'h0000);
        wr(16'hC000, 8'h00); rdx(16'h0000);
        wr(16'h0000, 8'hF0);

        cur_req = "R10";
        clr_group(8'h03); idle(20);
        cyc(1'b1, 1'b0, 1'b0, 16'h0, 8'h0);
        idle(2);
        cur_req = "R8";
        unlock(); wr(16'h0555, 8'h9A); wr(16'h0000, 8'h0D); idle(66);
        cur_req = "R9";
        clr_group(8'h03); idle(66);
        cur_req = "R6";
        unlock(); wr(16'h0555, 8'h9A); wr(16'h0000, 8'h0D);
        unlock(); wr(16'h0555, 8'h9A); wr(16'h0000, 8'h0E);
        idle(62);
        unlock(); wr(16'h0555, 8'h9A); wr(16'h0000, 8'h0E); idle(66);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule